// File: doc/BRIEF.md
# BCD On-Delay Timer

This block is one on-delay timer element for a cyclic scan controller. While its run input is held high it counts elapsed time in three BCD digits. Each count is one period of the selected time base, derived from a 1 kHz strobe. When the elapsed count reaches the preset, the done output rises. It stays high for as long as the run input remains high, and the count holds at the preset.

Dropping the run input clears both the count and the done flag. A rising edge on the clear input restarts the count from zero while the timer keeps running. The preset input carries three BCD digits and a two-bit time-base code. The readback word returns the elapsed digits together with that code, so the timer's state can be read in the same word format.

Top module: `bcd_ondelay_timer`

## Requirements
- R1: After reset, done is 0 and the elapsed digits time_word[11:0] are 000.
- R2: time_word holds the elapsed count as three BCD digits in bits 11:0, with the units digit in bits 3:0. Bits 13:12 repeat preset_word[13:12], and bits 15:14 read 0.
- R3: The time-base code preset_word[13:12] sets how many ms_tick strobes make one count: 00 gives 10, 01 gives 100, 10 gives 1000, and 11 also gives 1000. After run_en rises, the first count comes on the last of those strobes.
- R4: A clock edge with run_en low clears the elapsed count to 000, clears done and restarts the prescaler.
- R5: The first edge after clr goes from 0 to 1 clears the elapsed count and done. Holding clr high afterwards does not keep the count cleared.
- R6: Counting is decimal: a digit that goes past 9 returns to 0 and carries into the next digit (009 becomes 010, 099 becomes 100). Every digit of time_word always reads 9 or less.
- R7: done rises on the same edge on which the count reaches the preset. While run_en stays high, done stays high and the count holds at the preset.
- R8: A preset whose digits preset_word[11:0] include a nibble above 9 is treated as 999.
- R9: A cycle with ms_tick low changes neither the prescaler nor the elapsed count.
- R10: A preset of 000 raises done on the first edge with run_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle strobe at 1 kHz |
| run_en | input | 1 | Run level; the timer counts while this is high |
| clr | input | 1 | Clear; acts on its rising edge |
| preset_word | input | 14 | Preset: BCD digits in bits 11:0, time-base code in bits 13:12 |
| done | output | 1 | High once the elapsed count has reached the preset |
| time_word | output | 16 | Elapsed BCD count and time-base code |

## Verification
The properties take the inputs to be synchronous to clk and held stable across each edge. They also assume the preset is not changed in a cycle in which saturation is being checked. The saturation check applies only when preset_word is stable, so a lower preset loaded mid-run is allowed. The stimulus drives every input just after the falling edge. In the random phase it changes the preset only rarely. It keeps most presets small and on the 10-strobe base so that expiry happens often, and it mixes in invalid BCD presets and toggles of clr and run_en.

// File: rtl/timer_pkg.sv
package timer_pkg;
    parameter int TMR_DIGITS = 3;

    typedef enum logic [1:0] {
        TB_FINE    = 2'b00,
        TB_MID     = 2'b01,
        TB_COARSE  = 2'b10,
        TB_COARSE2 = 2'b11
    } tbase_e;
endpackage

// File: rtl/tbase_limit.sv
module tbase_limit #(
    parameter int DIV_FINE   = 10,
    parameter int DIV_MID    = 100,
    parameter int DIV_COARSE = 1000,
    parameter int PRE_W      = $clog2(DIV_COARSE)
) (
    input  timer_pkg::tbase_e code,
    output logic [PRE_W-1:0]  limit
);
    always_comb begin
        unique case (code)
            timer_pkg::TB_FINE: limit = PRE_W'(DIV_FINE - 1);
            timer_pkg::TB_MID:  limit = PRE_W'(DIV_MID - 1);
            default:            limit = PRE_W'(DIV_COARSE - 1);
        endcase
    end
endmodule

// File: rtl/bcd_preset_clamp.sv
module bcd_preset_clamp #(
    parameter int DIGITS = 3,
    localparam int CNT_W = 4 * DIGITS
) (
    input  logic [CNT_W-1:0] raw,
    output logic [CNT_W-1:0] val
);
    logic [DIGITS-1:0] bad;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        assign bad[i] = raw[4*i +: 4] > 4'd9;
    end

    assign val = (|bad) ? {DIGITS{4'd9}} : raw;
endmodule

// File: rtl/bcd_incr.sv
module bcd_incr #(
    parameter int DIGITS = 3,
    localparam int CNT_W = 4 * DIGITS
) (
    input  logic [CNT_W-1:0] a,
    output logic [CNT_W-1:0] y
);
    logic [DIGITS:0] cy;
    assign cy[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [3:0] d;
        assign d         = a[4*i +: 4];
        assign cy[i+1]   = cy[i] && (d == 4'd9);
        assign y[4*i +: 4] = !cy[i] ? d : ((d == 4'd9) ? 4'd0 : d + 4'd1);
    end
endmodule

// File: rtl/bcd_ondelay_timer.sv
module bcd_ondelay_timer #(
    parameter int DIGITS     = timer_pkg::TMR_DIGITS,
    parameter int DIV_FINE   = 10,
    parameter int DIV_MID    = 100,
    parameter int DIV_COARSE = 1000,
    localparam int CNT_W     = 4 * DIGITS,
    localparam int PRE_W     = $clog2(DIV_COARSE),
    localparam int WORD_W    = CNT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              run_en,
    input  logic              clr,
    input  logic [CNT_W+1:0]  preset_word,
    output logic              done,
    output logic [WORD_W-1:0] time_word
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             clr_prev;
    } state_t;

    state_t st_d, st_q;

    timer_pkg::tbase_e code;
    logic [PRE_W-1:0]  limit;
    logic [CNT_W-1:0]  preset_val;
    logic [CNT_W-1:0]  cnt_inc;

    assign code = timer_pkg::tbase_e'(preset_word[CNT_W+1:CNT_W]);

    tbase_limit #(
        .DIV_FINE  (DIV_FINE),
        .DIV_MID   (DIV_MID),
        .DIV_COARSE(DIV_COARSE),
        .PRE_W     (PRE_W)
    ) u_limit (
        .code (code),
        .limit(limit)
    );

    bcd_preset_clamp #(.DIGITS(DIGITS)) u_clamp (
        .raw(preset_word[CNT_W-1:0]),
        .val(preset_val)
    );

    bcd_incr #(.DIGITS(DIGITS)) u_incr (
        .a(st_q.cnt),
        .y(cnt_inc)
    );

    always_comb begin
        logic clr_rise;
        logic step;
        st_d          = st_q;
        st_d.clr_prev = clr;
        clr_rise      = clr && !st_q.clr_prev;
        step          = ms_tick && (st_q.pre >= limit);
        if (!run_en || clr_rise) begin
            st_d.pre  = '0;
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else begin
            if (ms_tick) begin
                st_d.pre = step ? '0 : st_q.pre + PRE_W'(1);
            end
            if (step && (st_q.cnt < preset_val)) begin
                st_d.cnt = cnt_inc;
            end
            st_d.done = (st_d.cnt >= preset_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign time_word = {2'b00, preset_word[CNT_W+1:CNT_W], st_q.cnt};
endmodule

// File: rtl/timer_checks.sv
module timer_checks #(
    parameter int DIGITS = 3,
    localparam int CNT_W = 4 * DIGITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              run_en,
    input logic              clr,
    input logic [CNT_W+1:0]  preset_word,
    input logic              done,
    input logic [CNT_W+3:0]  time_word
);
    // R4: an idle cycle empties the timer
    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (time_word[CNT_W-1:0] == '0) && !done);

    // R5: rising clear empties the timer
    p_clr_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr) |=> (time_word[CNT_W-1:0] == '0) && !done);

    // R7: count holds once expired
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run_en && !clr && $stable(preset_word)) |=> $stable(time_word[CNT_W-1:0]));

    // R7: done only rises while running
    p_done_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run_en));

    // R9: no strobe, no count change
    p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && run_en && !clr) |=> $stable(time_word[CNT_W-1:0]));

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        // R6: every digit stays decimal
        p_digit_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
            time_word[4*i +: 4] <= 4'd9);
    end
endmodule

bind bcd_ondelay_timer timer_checks #(.DIGITS(DIGITS)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .run_en     (run_en),
    .clr        (clr),
    .preset_word(preset_word),
    .done       (done),
    .time_word  (time_word)
);

// File: tb/test_bcd_ondelay_timer.sv
`timescale 1ns/1ps
module test_bcd_ondelay_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        run_en = 1'b0;
    logic        clr = 1'b0;
    logic [13:0] preset_word = 14'h0003;
    logic        done;
    logic [15:0] time_word;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    bcd_ondelay_timer i_bcd_ondelay_timer (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .run_en(run_en),
        .clr(clr), .preset_word(preset_word), .done(done), .time_word(time_word)
    );

    function automatic int div_of(input logic [1:0] c);
        return (c == 2'b00) ? 10 : (c == 2'b01) ? 100 : 1000;
    endfunction

    function automatic int preset_of(input logic [13:0] p);
        if (p[3:0] > 9 || p[7:4] > 9 || p[11:8] > 9) return 999;
        return p[11:8] * 100 + p[7:4] * 10 + p[3:0];
    endfunction

    function automatic logic [11:0] to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    // reference model
    int m_pre, m_cnt;
    bit m_done, m_clrp;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= 0; m_cnt <= 0; m_done <= 0; m_clrp <= 0;
        end else begin : mdl
            int c;
            int pv;
            c  = m_cnt;
            pv = preset_of(preset_word);
            m_clrp <= clr;
            if (!run_en || (clr && !m_clrp)) begin
                m_pre <= 0; m_cnt <= 0; m_done <= 0;
            end else begin
                if (ms_tick) begin
                    if (m_pre >= div_of(preset_word[13:12]) - 1) begin
                        m_pre <= 0;
                        if (c < pv) c = c + 1;
                    end else begin
                        m_pre <= m_pre + 1;
                    end
                end
                m_cnt  <= c;
                m_done <= (c >= pv);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        wait_n(1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        wait_n(3);
        chk("R1 reset count/word", time_word, 16'h0000);
        chk("R1 reset done", {15'd0, done}, 16'd0);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1 idle after reset", {15'd0, done, time_word[11:0]}, 16'h0000);

        // R3 fine base, R7 expiry and hold
        ms_tick = 1'b1; preset_word = 14'h0003; run_en = 1'b1;
        wait_n(9);  chk("R3 fine before first count", time_word, 16'h0000);
        wait_n(1);  chk("R3 fine first count", time_word, 16'h0001);
        wait_n(19); chk("R7 not yet done", {15'd0, done}, 16'd0);
        chk("R7 count 2", time_word, 16'h0002);
        wait_n(1);  chk("R7 done at preset", {15'd0, done}, 16'd1);
        chk("R7 count at preset", time_word, 16'h0003);
        wait_n(50); chk("R7 saturated count", time_word, 16'h0003);
        chk("R7 done held", {15'd0, done}, 16'd1);
        run_en = 1'b0;
        wait_n(1);  chk("R4 run low clears", {15'd0, done, time_word[11:0]}, 16'h0000);

        // R3 mid base, R2 word layout
        preset_word = 14'h1002; run_en = 1'b1;
        wait_n(199); chk("R3 mid count 1", time_word, 16'h1001);
        wait_n(1);   chk("R2 word with mid code", time_word, 16'h1002);
        chk("R3 mid done", {15'd0, done}, 16'd1);
        stop_run();

        // R3 coarse base and code 11
        preset_word = 14'h2001; run_en = 1'b1;
        wait_n(999); chk("R3 coarse before count", time_word, 16'h2000);
        wait_n(1);   chk("R3 coarse count", time_word, 16'h2001);
        stop_run();
        preset_word = 14'h3001; run_en = 1'b1;
        wait_n(999); chk("R3 code 11 before count", time_word, 16'h3000);
        wait_n(1);   chk("R3 code 11 count", {done, time_word[14:0]}, 16'hB001);
        stop_run();

        // R6 decimal carries
        preset_word = 14'h0120; run_en = 1'b1;
        wait_n(90);  chk("R6 digit 9", time_word, 16'h0009);
        wait_n(10);  chk("R6 carry to tens", time_word, 16'h0010);
        wait_n(890); chk("R6 count 099", time_word, 16'h0099);
        wait_n(10);  chk("R6 carry to hundreds", time_word, 16'h0100);
        wait_n(50);  chk("R6 count 105", time_word, 16'h0105);

        // R5 clear on rising edge only
        clr = 1'b1;
        wait_n(1);  chk("R5 rise clears", time_word, 16'h0000);
        wait_n(10); chk("R5 held clr counts again", time_word, 16'h0001);
        clr = 1'b0;
        stop_run();

        // R9 no strobe holds prescaler and count
        preset_word = 14'h0005; run_en = 1'b1;
        wait_n(5); ms_tick = 1'b0;
        wait_n(50); chk("R9 count held without strobe", time_word, 16'h0000);
        ms_tick = 1'b1;
        wait_n(4); chk("R9 prescaler resumed not early", time_word, 16'h0000);
        wait_n(1); chk("R9 prescaler kept phase", time_word, 16'h0001);
        stop_run();

        // R8 invalid preset
        preset_word = 14'h00A1; run_en = 1'b1;
        wait_n(9980); chk("R8 count 998 not done", {done, time_word[14:0]}, 16'h0998);
        wait_n(10);   chk("R8 done at 999", {done, time_word[14:0]}, 16'h8999);
        wait_n(30);   chk("R8 held at 999", time_word, 16'h0999);
        stop_run();

        // R10 zero preset
        preset_word = 14'h0000; run_en = 1'b1;
        chk("R10 done low before edge", {15'd0, done}, 16'd0);
        wait_n(1); chk("R10 done after one edge", {15'd0, done}, 16'd1);
        stop_run();

        // random phase against the model (R3 R4 R5 R7 R8 R9)
        model_on = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            ms_tick = ($urandom % 10) < 7;
            if ($urandom % 150 == 0) run_en = ~run_en;
            else if (!run_en && ($urandom % 8 == 0)) run_en = 1'b1;
            if ($urandom % 60 == 0) clr = ~clr;
            if ($urandom % 400 == 0) begin
                logic [3:0] h;
                h = ($urandom % 16 == 0) ? 4'hB : 4'h0;
                preset_word = {($urandom % 8 == 0) ? 2'b01 : 2'b00,
                               h, 4'($urandom % 2), 4'($urandom % 10)};
            end
            wait_n(1);
            chk("R7 random done vs model", {15'd0, done}, {15'd0, m_done});
            chk("R3 random count vs model", time_word,
                {2'b00, preset_word[13:12], to_bcd(m_cnt)});
        end
        summary();
    end
endmodule